// File: doc/BRIEF.md
# Escaped Packet Byte Deframer

This block sits on the receive side of a serial register-access link. It takes a raw byte stream, one byte per cycle with a valid strobe, and recovers the payload bytes of one packet at a time. Link fill bytes are dropped wherever they appear, and so is everything seen while the block is hunting for a start marker. Escape sequences are undone, and the one-channel rule is enforced. The final payload byte is flagged: the sender places an end marker just before that byte, not after it.

The protocol uses fixed code values. The start marker is 0x7A, the end marker is 0x7B, the channel marker is 0x7C and the fill byte is 0x4A. There are two escape codes, 0x7D and 0x4D. An escaped byte is restored by XOR with 0x20.

Framing violations produce a one-cycle error pulse with a kind code. A packet that goes quiet for longer than a programmable number of cycles produces a one-cycle timeout pulse. After either event the block goes back to hunting for a start marker. Whole-packet buffering and transaction decoding belong to the blocks downstream.

Top module: `esc_deframer`

## Requirements
- R1: After reset, out_valid, out_last, err_pulse and timeout_pulse are 0, err_kind is 0, and the block is hunting for a start marker.
- R2: While hunting, every byte other than 0x7A is discarded without output or error, including the marker and escape codes.
- R3: A fill byte 0x4A inside a packet is discarded and changes no state: a pending escape, end or channel flag survives it.
- R4: Inside a packet, 0x7D or 0x4D arms an escape. The next data byte is then output XOR 0x20 and the escape is cleared.
- R5: The byte after 0x7C (fill bytes skipped) must be 0x00, and it is consumed silently. Any other value gives err_pulse with err_kind 1 and returns the block to hunting.
- R6: A 0x7A inside a packet restarts the packet and clears the pending escape, end and channel flags.
- R7: An escape code that arrives while an escape is already pending gives err_pulse with err_kind 3.
- R8: A 0x7B or 0x7C that arrives while an escape is pending, or after a 0x7B, gives err_pulse with err_kind 2.
- R9: The first data byte after 0x7B is output with out_last=1. The block then hunts again, and later non-0x7A bytes produce nothing.
- R10: After any error pulse, bytes are ignored until the next 0x7A.
- R11: Inside a packet, timeout_limit consecutive cycles without a non-fill byte give a one-cycle timeout_pulse and a return to hunting. Fill bytes count as quiet cycles. A timeout_limit of 0 disables the timeout.
- R12: A non-fill byte accepted in the cycle the timeout would expire is processed normally, and no timeout is raised. A fill byte in that cycle does not prevent the timeout.
- R13: Each output event appears in the cycle after the input byte that caused it. out_valid and err_pulse are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | in_byte carries a link byte this cycle |
| in_byte | input | 8 | Raw link byte |
| timeout_limit | input | TO_W | Quiet cycles allowed inside a packet; 0 disables |
| out_valid | output | 1 | out_byte holds a payload byte |
| out_byte | output | 8 | Recovered payload byte |
| out_last | output | 1 | This payload byte ends the packet |
| err_pulse | output | 1 | One-cycle framing error indication |
| err_kind | output | 2 | 1 channel number, 2 misplaced marker, 3 double escape; 0 otherwise |
| timeout_pulse | output | 1 | One-cycle inactivity timeout indication |

## Verification
The inactivity timer can expire in the same cycle that a byte arrives, so timeout and byte processing compete. The bench opens a packet, holds the link quiet for exactly one cycle less than the limit, and then sends a data byte on the expiry edge. The scoreboard expects that data byte and no timeout pulse. The same setup with a fill byte on the expiry edge must instead yield a timeout pulse, which pins the expiry cycle exactly.

// File: rtl/dfr_pkg.sv
package dfr_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      BC_DATA = 3'd0,
      BC_FILL = 3'd1,
      BC_SOP  = 3'd2,
      BC_EOP  = 3'd3,
      BC_CHAN = 3'd4,
      BC_ESC  = 3'd5
   } byte_cls_t;

   typedef enum logic [1:0] {
      EK_NONE  = 2'd0,
      EK_CHAN  = 2'd1,
      EK_ORDER = 2'd2,
      EK_DESC  = 2'd3
   } err_kind_t;

   typedef struct packed {
      logic esc;
      logic eop;
      logic chan;
   } pkt_flags_t;

endpackage

// File: rtl/dfr_classify.sv
module dfr_classify
   import dfr_pkg::*;
#(
   parameter int                        NUM_ESC   = 2,
   parameter logic [NUM_ESC*BYTE_W-1:0] ESC_LIST  = 16'h7D4D,
   parameter logic [BYTE_W-1:0]         SOP_CODE  = 8'h7A,
   parameter logic [BYTE_W-1:0]         EOP_CODE  = 8'h7B,
   parameter logic [BYTE_W-1:0]         CHAN_CODE = 8'h7C,
   parameter logic [BYTE_W-1:0]         FILL_CODE = 8'h4A
) (
   input  logic [BYTE_W-1:0] code_i,
   output byte_cls_t         cls_o
);

   logic [NUM_ESC-1:0] esc_hit;

   generate
      for (genvar g = 0; g < NUM_ESC; g++) begin : g_esc
         assign esc_hit[g] = (code_i == ESC_LIST[g*BYTE_W +: BYTE_W]);
      end
   endgenerate

   always_comb begin
      if (code_i == FILL_CODE)      cls_o = BC_FILL;
      else if (code_i == SOP_CODE)  cls_o = BC_SOP;
      else if (code_i == EOP_CODE)  cls_o = BC_EOP;
      else if (code_i == CHAN_CODE) cls_o = BC_CHAN;
      else if (|esc_hit)            cls_o = BC_ESC;
      else                          cls_o = BC_DATA;
   end

endmodule

// File: rtl/dfr_timer.sv
module dfr_timer #(
   parameter int TO_W   = 16,
   parameter bit ENABLE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            active,
   input  logic            restart,
   input  logic [TO_W-1:0] limit,
   output logic            expire
);

   generate
      if (ENABLE) begin : g_on
         logic [TO_W-1:0] cnt;
         logic            armed;

         assign armed  = active && !restart && (limit != '0);
         assign expire = armed && (cnt == (limit - 1'b1));

         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt <= '0;
            else if (!armed || expire)
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end
      end else begin : g_off
         logic unused_tmr;
         assign unused_tmr = ^{clk, rst_n, active, restart, limit};
         assign expire     = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/dfr_parse.sv
module dfr_parse
   import dfr_pkg::*;
#(
   parameter logic [BYTE_W-1:0] XOR_MASK = 8'h20,
   parameter logic [BYTE_W-1:0] CHAN_ID  = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_byte,
   input  byte_cls_t         cls,
   input  logic              expire,
   output logic              in_pkt,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_byte,
   output logic              out_last,
   output logic              err_pulse,
   output logic [1:0]        err_kind,
   output logic              timeout_pulse
);

   logic              hunt_q,  hunt_d;
   pkt_flags_t        flg_q,   flg_d;
   logic              ov_d,    ol_d,  to_d;
   logic [BYTE_W-1:0] ob_d;
   err_kind_t         ek_d;

   assign in_pkt = !hunt_q;

   always_comb begin
      hunt_d = hunt_q;
      flg_d  = flg_q;
      ov_d   = 1'b0;
      ol_d   = 1'b0;
      ob_d   = '0;
      ek_d   = EK_NONE;
      to_d   = 1'b0;
      if (expire) begin
         to_d   = 1'b1;
         hunt_d = 1'b1;
         flg_d  = '0;
      end else if (in_valid) begin
         if (hunt_q) begin
            if (cls == BC_SOP) begin
               hunt_d = 1'b0;
               flg_d  = '0;
            end
         end else if (cls == BC_FILL) begin
            hunt_d = hunt_q;
         end else if (flg_q.chan) begin
            if (in_byte != CHAN_ID) ek_d = EK_CHAN;
            else                    flg_d.chan = 1'b0;
         end else begin
            unique case (cls)
               BC_SOP:  flg_d = '0;
               BC_EOP: begin
                  if (flg_q.esc || flg_q.eop) ek_d = EK_ORDER;
                  else                        flg_d.eop = 1'b1;
               end
               BC_CHAN: begin
                  if (flg_q.esc || flg_q.eop) ek_d = EK_ORDER;
                  else                        flg_d.chan = 1'b1;
               end
               BC_ESC: begin
                  if (flg_q.esc) ek_d = EK_DESC;
                  else           flg_d.esc = 1'b1;
               end
               default: begin
                  ov_d      = 1'b1;
                  ob_d      = flg_q.esc ? (in_byte ^ XOR_MASK) : in_byte;
                  ol_d      = flg_q.eop;
                  flg_d.esc = 1'b0;
                  if (flg_q.eop) begin
                     hunt_d = 1'b1;
                     flg_d  = '0;
                  end
               end
            endcase
         end
         if (ek_d != EK_NONE) begin
            hunt_d = 1'b1;
            flg_d  = '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hunt_q        <= 1'b1;
         flg_q         <= '0;
         out_valid     <= 1'b0;
         out_byte      <= '0;
         out_last      <= 1'b0;
         err_pulse     <= 1'b0;
         err_kind      <= 2'd0;
         timeout_pulse <= 1'b0;
      end else begin
         hunt_q        <= hunt_d;
         flg_q         <= flg_d;
         out_valid     <= ov_d;
         out_byte      <= ob_d;
         out_last      <= ol_d;
         err_pulse     <= (ek_d != EK_NONE);
         err_kind      <= ek_d;
         timeout_pulse <= to_d;
      end
   end

endmodule

// File: rtl/esc_deframer.sv
module esc_deframer
   import dfr_pkg::*;
#(
   parameter int                        TO_W       = 16,
   parameter bit                        TIMEOUT_EN = 1'b1,
   parameter int                        NUM_ESC    = 2,
   parameter logic [NUM_ESC*BYTE_W-1:0] ESC_LIST   = 16'h7D4D,
   parameter logic [BYTE_W-1:0]         SOP_CODE   = 8'h7A,
   parameter logic [BYTE_W-1:0]         EOP_CODE   = 8'h7B,
   parameter logic [BYTE_W-1:0]         CHAN_CODE  = 8'h7C,
   parameter logic [BYTE_W-1:0]         FILL_CODE  = 8'h4A,
   parameter logic [BYTE_W-1:0]         XOR_MASK   = 8'h20,
   parameter logic [BYTE_W-1:0]         CHAN_ID    = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_byte,
   input  logic [TO_W-1:0]   timeout_limit,
   output logic              out_valid,
   output logic [7:0]        out_byte,
   output logic              out_last,
   output logic              err_pulse,
   output logic [1:0]        err_kind,
   output logic              timeout_pulse
);

   generate
      if (TO_W < 2 || TO_W > 32) begin : g_bad_tow
         $error("esc_deframer: TO_W must lie in 2..32");
      end
      if (NUM_ESC < 1) begin : g_bad_esc
         $error("esc_deframer: at least one escape code is needed");
      end
   endgenerate

   byte_cls_t cls;
   logic      in_pkt;
   logic      expire;
   logic      restart;

   assign restart = in_valid && (cls != BC_FILL);

   dfr_classify #(
      .NUM_ESC   (NUM_ESC),
      .ESC_LIST  (ESC_LIST),
      .SOP_CODE  (SOP_CODE),
      .EOP_CODE  (EOP_CODE),
      .CHAN_CODE (CHAN_CODE),
      .FILL_CODE (FILL_CODE)
   ) u_cls (
      .code_i (in_byte),
      .cls_o  (cls)
   );

   dfr_timer #(
      .TO_W   (TO_W),
      .ENABLE (TIMEOUT_EN)
   ) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (in_pkt),
      .restart (restart),
      .limit   (timeout_limit),
      .expire  (expire)
   );

   dfr_parse #(
      .XOR_MASK (XOR_MASK),
      .CHAN_ID  (CHAN_ID)
   ) u_parse (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid      (in_valid),
      .in_byte       (in_byte),
      .cls           (cls),
      .expire        (expire),
      .in_pkt        (in_pkt),
      .out_valid     (out_valid),
      .out_byte      (out_byte),
      .out_last      (out_last),
      .err_pulse     (err_pulse),
      .err_kind      (err_kind),
      .timeout_pulse (timeout_pulse)
   );

endmodule

module dfr_checker #(
   parameter int         TO_W      = 16,
   parameter logic [7:0] FILL_CODE = 8'h4A
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [7:0]      in_byte,
   input logic [TO_W-1:0] timeout_limit,
   input logic            out_valid,
   input logic            out_last,
   input logic            err_pulse,
   input logic [1:0]      err_kind,
   input logic            timeout_pulse
);

   assert_data_err_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_valid && err_pulse));

   assert_latency_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> (!out_valid && !err_pulse));

   assert_last_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   assert_kind_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> (err_kind != 2'd0));

   assert_kind_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !err_pulse |-> (err_kind == 2'd0));

   assert_fill_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && (in_byte == FILL_CODE)) |-> (!out_valid && !err_pulse));

   assert_timeout_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_pulse |=> !timeout_pulse);

   assert_timeout_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(timeout_limit) == '0) |-> !timeout_pulse);

   assert_byte_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_pulse |-> !$past(in_valid && (in_byte != FILL_CODE)));

endmodule

bind esc_deframer dfr_checker #(
   .TO_W      (TO_W),
   .FILL_CODE (FILL_CODE)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_valid      (in_valid),
   .in_byte       (in_byte),
   .timeout_limit (timeout_limit),
   .out_valid     (out_valid),
   .out_last      (out_last),
   .err_pulse     (err_pulse),
   .err_kind      (err_kind),
   .timeout_pulse (timeout_pulse)
);

// File: tb/esc_deframer_test.sv
module esc_deframer_test;

   localparam int CLK_PERIOD = 10;
   localparam int TO_W       = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [7:0]      in_byte = 8'h00;
   logic [TO_W-1:0] timeout_limit = '0;
   logic            out_valid, out_last, err_pulse, timeout_pulse;
   logic [7:0]      out_byte;
   logic [1:0]      err_kind;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   typedef struct {
      int         kind;   // 0 data, 1 error, 2 timeout
      logic [7:0] b;
      logic       last;
      logic [1:0] ek;
      string      req;
   } exp_t;

   exp_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   esc_deframer #(.TO_W(TO_W)) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid      (in_valid),
      .in_byte       (in_byte),
      .timeout_limit (timeout_limit),
      .out_valid     (out_valid),
      .out_byte      (out_byte),
      .out_last      (out_last),
      .err_pulse     (err_pulse),
      .err_kind      (err_kind),
      .timeout_pulse (timeout_pulse)
   );

   task automatic exp_d(input logic [7:0] b, input logic last, input string req);
      exp_t e;
      e.kind = 0; e.b = b; e.last = last; e.ek = 2'd0; e.req = req;
      q.push_back(e);
   endtask

   task automatic exp_e(input logic [1:0] ek, input string req);
      exp_t e;
      e.kind = 1; e.b = 8'h00; e.last = 1'b0; e.ek = ek; e.req = req;
      q.push_back(e);
   endtask

   task automatic exp_to(input string req);
      exp_t e;
      e.kind = 2; e.b = 8'h00; e.last = 1'b0; e.ek = 2'd0; e.req = req;
      q.push_back(e);
   endtask

   task automatic send(input logic [7:0] b);
      in_valid = 1'b1;
      in_byte  = b;
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      in_byte  = 8'h00;
   endtask

   task automatic quiet(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !finished && (out_valid || err_pulse || timeout_pulse)) begin
         int   ak;
         exp_t e;
         ak = timeout_pulse ? 2 : (err_pulse ? 1 : 0);
         if (q.size() == 0) begin
            check(1'b0, "R13", "unexpected event kind", ak, 3);
         end else begin
            e = q.pop_front();
            check(ak == e.kind, e.req, "event kind", ak, e.kind);
            if (e.kind == 0)
               check(out_byte == e.b && out_last == e.last, e.req, "byte/last",
                     {out_last, out_byte}, {e.last, e.b});
            if (e.kind == 1)
               check(err_kind == e.ek, e.req, "err_kind", err_kind, e.ek);
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      // R1: reset state
      check(!out_valid && !out_last && !err_pulse && !timeout_pulse && err_kind == 2'd0,
            "R1", "outputs in reset",
            {out_valid, out_last, err_pulse, timeout_pulse, err_kind}, 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      quiet(2);
      check(!out_valid && !err_pulse && !timeout_pulse, "R1", "outputs after reset",
            {out_valid, err_pulse, timeout_pulse}, 0);

      // R2: noise while hunting is dropped
      send(8'h41); send(8'h7B); send(8'h7D); send(8'h7C); send(8'h05);
      // R9: plain packet with channel, last byte after end marker
      exp_d(8'h10, 1'b0, "R9");
      exp_d(8'h22, 1'b1, "R9");
      send(8'h7A); send(8'h7C); send(8'h00); send(8'h10); send(8'h7B); send(8'h22);
      // R13: result visible right after the capturing edge
      check(out_valid && out_last && out_byte == 8'h22, "R13", "one-cycle latency",
            {out_valid, out_last, out_byte}, {2'b11, 8'h22});
      quiet(2);

      // R4: both escape codes
      exp_d(8'h7A, 1'b0, "R4");
      exp_d(8'h4A, 1'b0, "R4");
      exp_d(8'h33, 1'b1, "R4");
      send(8'h7A); send(8'h7D); send(8'h5A); send(8'h4D); send(8'h6A);
      send(8'h7B); send(8'h33);
      quiet(2);

      // R3: fill bytes everywhere, escape survives a fill byte
      exp_d(8'h7D, 1'b0, "R3");
      exp_d(8'h44, 1'b1, "R3");
      send(8'h7A); send(8'h4A); send(8'h7D); send(8'h4A); send(8'h5D);
      send(8'h4A); send(8'h7B); send(8'h4A); send(8'h44);
      quiet(2);

      // R9: after the last byte, non-start bytes are dropped; escaped last byte
      send(8'h55);
      exp_d(8'h7B, 1'b1, "R9");
      send(8'h7A); send(8'h7B); send(8'h7D); send(8'h5B);
      quiet(2);

      // R5: non-zero channel number
      exp_e(2'd1, "R5");
      send(8'h7A); send(8'h7C); send(8'h01);
      // R10: ignored until next start marker
      send(8'h66); send(8'h7B); send(8'h77);
      exp_d(8'h88, 1'b0, "R5");
      exp_d(8'h99, 1'b1, "R10");
      send(8'h7A); send(8'h7C); send(8'h4A); send(8'h00); send(8'h88);
      send(8'h7B); send(8'h99);
      quiet(2);

      // R6: restart clears escape and end flags
      exp_d(8'h20, 1'b0, "R6");
      exp_d(8'h30, 1'b0, "R6");
      exp_d(8'h31, 1'b1, "R6");
      send(8'h7A); send(8'h7D); send(8'h7A); send(8'h20);
      send(8'h7B); send(8'h7A); send(8'h30); send(8'h7B); send(8'h31);
      quiet(2);

      // R7: double escape
      exp_e(2'd3, "R7");
      send(8'h7A); send(8'h7D); send(8'h4D);
      exp_e(2'd3, "R7");
      send(8'h7A); send(8'h4D); send(8'h7D);
      quiet(2);

      // R8: misplaced markers
      exp_e(2'd2, "R8");
      send(8'h7A); send(8'h7D); send(8'h7B);
      exp_e(2'd2, "R8");
      send(8'h7A); send(8'h7B); send(8'h7C);
      exp_e(2'd2, "R8");
      send(8'h7A); send(8'h7D); send(8'h7C);
      exp_e(2'd2, "R8");
      send(8'h7A); send(8'h7B); send(8'h7B);
      quiet(2);

      // R11: timeout with idle link, then with fill bytes
      timeout_limit = 16'd8;
      exp_to("R11");
      send(8'h7A); quiet(8);
      send(8'h12);
      quiet(2);
      exp_to("R11");
      send(8'h7A);
      for (int i = 0; i < 8; i++) send(8'h4A);
      quiet(2);

      // R12: byte on the expiry edge wins; fill byte there does not
      exp_d(8'h13, 1'b0, "R12");
      exp_d(8'h14, 1'b1, "R12");
      send(8'h7A); quiet(7); send(8'h13); send(8'h7B); send(8'h14);
      quiet(2);
      exp_to("R12");
      send(8'h7A); quiet(7); send(8'h4A);
      quiet(2);

      // R11: zero limit disables timeout
      timeout_limit = '0;
      exp_d(8'h15, 1'b1, "R11");
      send(8'h7A); quiet(20); send(8'h7B); send(8'h15);
      quiet(4);

      check(q.size() == 0, "R13", "events outstanding", q.size(), 0);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule